// File: doc/BRIEF.md
# 16-bit Host Bus to 32-bit Register and FIFO Bridge

This block connects an asynchronous, SRAM-like 16-bit host bus to a 32-bit internal world. The host drives an active-low chip select, an active-low read strobe, an active-low write strobe and a 7-bit word address. Every internal transfer is 32 bits wide and is made from two 16-bit host cycles. Address bit 0 of the port picks the half of the word.

An access goes to one of two places. The first is a control/status register space, indexed by the upper six address bits. The second is the data FIFO port: writes push the TX FIFO and reads pop the RX FIFO. A FIFO-select input sends every access to the FIFO port and ignores the upper address. FIFO accesses can swap the order of the two halves. Register accesses never do.

The strobes pass through a two-flop synchronizer into the core clock. Each action happens when its strobe is released. While the system is in a low-power state, a qualified write strobe raises a wake request.

Top module: `sram_host_bridge`

## Requirements
- R1: After reset, `data_oe_o`, `wake_o`, `csr_wr_o`, `txf_push_o` and `rxf_pop_o` are all low.
- R2: A write with `addr_i[0]`=0 only stores a half and emits nothing. The write with `addr_i[0]`=1 that follows raises `csr_wr_o` for one cycle. The word on `csr_wdata_o` is {upper write data, lower write data}, and `csr_addr_o` equals `addr_i[6:1]`.
- R3: A read with `addr_i[0]`=0 returns bits [15:0] of the selected 32-bit source and captures the whole word at that moment. The next read with `addr_i[0]`=1 returns bits [31:16] of that captured word, even if the source has changed since.
- R4: An address with `addr_i[6:2]`=0 selects the FIFO port. A completed word write pushes `txf_push_o` with no `csr_wr_o`. Release of a read with `addr_i[0]`=1 pops `rxf_pop_o` exactly once.
- R5: While `fifo_sel_i` is high, every access goes to the FIFO port whatever the value of `addr_i[6:1]`, and `csr_wr_o` stays low.
- R6: While `fifo_swap_i` is high, FIFO accesses with `addr_i[0]`=0 map to bits [31:16] and those with `addr_i[0]`=1 map to bits [15:0]. Register accesses ignore `fifo_swap_i`.
- R7: Back-to-back read pairs on the FIFO port return consecutive RX words, and each pair pops once.
- R8: `wake_o` is high while `low_power_i` is high and chip select plus write strobe are held low. It stays low for reads and when `low_power_i` is low.
- R9: Strobes that arrive while `cs_ni` is high cause no push, no pop, no register write and no output enable.
- R10: `data_oe_o` is high only while a qualified read strobe is held, seen three clocks late through the synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| addr_i | input | 7 | Word address; bit 0 selects the half |
| fifo_sel_i | input | 1 | Forces accesses to the FIFO port |
| fifo_swap_i | input | 1 | Swaps half order for FIFO accesses |
| low_power_i | input | 1 | System is in a low-power state |
| data_i | input | 16 | Host write data |
| data_o | output | 16 | Host read data |
| data_oe_o | output | 1 | Enable for the host data pin drivers |
| wake_o | output | 1 | Wake request |
| csr_addr_o | output | 6 | Register word index |
| csr_wdata_o | output | 32 | Register write word |
| csr_wr_o | output | 1 | Register write pulse |
| csr_rdata_i | input | 32 | Register read word |
| txf_data_o | output | 32 | TX FIFO push word |
| txf_push_o | output | 1 | TX FIFO push pulse |
| rxf_data_i | input | 32 | RX FIFO head word |
| rxf_pop_o | output | 1 | RX FIFO pop pulse |

## Verification
Two decisions fall in the same cycle: the FIFO-select override and the address decode. The bench drives an address in the register range, such as 0x7E/0x7F, with `fifo_sel_i` high. It then judges that the word reaches the TX FIFO and that the register write count does not move. In a second pairing, the swap input is held high during a register write. The expected result is that the register word keeps the unswapped order in that cycle, while a FIFO write made under the same setting comes out swapped.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
  typedef enum logic {REG_CSR = 1'b0, REG_FIFO = 1'b1} region_e;
endpackage

// File: rtl/sbr_sync.sv
module sbr_sync #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] meta_q, sync_q;
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q[i] <= 1'b1;
        sync_q[i] <= 1'b1;
      end else begin
        meta_q[i] <= d_i[i];
        sync_q[i] <= meta_q[i];
      end
    end
  end
  assign q_o = sync_q;
endmodule

// File: rtl/sbr_decode.sv
module sbr_decode
  import sbr_pkg::*;
#(
  parameter int AW    = 7,
  parameter int TAG_W = 5
) (
  input  logic          fifo_sel_i,
  input  logic [AW-1:0] addr_i,
  output region_e       region_o,
  output logic [AW-2:0] word_idx_o,
  output logic          hi_half_o
);
  always_comb begin
    region_o   = (fifo_sel_i || addr_i[AW-1 -: TAG_W] == '0) ? REG_FIFO : REG_CSR;
    word_idx_o = addr_i[AW-1:1];
    hi_half_o  = addr_i[0];
  end
endmodule

// File: rtl/sbr_wr_pack.sv
module sbr_wr_pack #(
  parameter int HW = 16,
  localparam int WW = 2 * HW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          lo_end_i,
  input  logic          hi_end_i,
  input  logic          swap_i,
  input  logic          to_fifo_i,
  input  logic [HW-1:0] data_i,
  output logic [WW-1:0] word_o,
  output logic          push_fifo_o,
  output logic          push_csr_o
);
  logic [HW-1:0] hold_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q      <= '0;
      word_o      <= '0;
      push_fifo_o <= 1'b0;
      push_csr_o  <= 1'b0;
    end else begin
      if (lo_end_i) hold_q <= data_i;
      if (hi_end_i) word_o <= swap_i ? {hold_q, data_i} : {data_i, hold_q};
      push_fifo_o <= hi_end_i & to_fifo_i;
      push_csr_o  <= hi_end_i & ~to_fifo_i;
    end
  end

  a_r2_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_fifo_o || push_csr_o) |=> !(push_fifo_o || push_csr_o));
endmodule

// File: rtl/sbr_rd_path.sv
module sbr_rd_path #(
  parameter int HW = 16,
  localparam int WW = 2 * HW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          lo_start_i,
  input  logic          hi_start_i,
  input  logic          swap_i,
  input  logic [WW-1:0] src_i,
  output logic [HW-1:0] dout_o
);
  logic [WW-1:0] snap_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_q <= '0;
      dout_o <= '0;
    end else if (lo_start_i) begin
      snap_q <= src_i;
      dout_o <= swap_i ? src_i[WW-1:HW] : src_i[HW-1:0];
    end else if (hi_start_i) begin
      dout_o <= swap_i ? snap_q[HW-1:0] : snap_q[WW-1:HW];
    end
  end
endmodule

// File: rtl/sram_host_bridge.sv
module sram_host_bridge
  import sbr_pkg::*;
#(
  parameter int HW    = 16,
  parameter int AW    = 7,
  parameter int TAG_W = 5,
  localparam int WW   = 2 * HW,
  localparam int IW   = AW - 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_ni,
  input  logic          rd_ni,
  input  logic          wr_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          fifo_sel_i,
  input  logic          fifo_swap_i,
  input  logic          low_power_i,
  input  logic [HW-1:0] data_i,
  output logic [HW-1:0] data_o,
  output logic          data_oe_o,
  output logic          wake_o,
  output logic [IW-1:0] csr_addr_o,
  output logic [WW-1:0] csr_wdata_o,
  output logic          csr_wr_o,
  input  logic [WW-1:0] csr_rdata_i,
  output logic [WW-1:0] txf_data_o,
  output logic          txf_push_o,
  input  logic [WW-1:0] rxf_data_i,
  output logic          rxf_pop_o
);
  logic [2:0] strb_s;
  logic       s_rd, s_wr, rd_q, wr_q;
  logic       rd_start, rd_end, wr_end;
  region_e    region;
  logic       hi_half, is_fifo, swap_eff;
  logic [WW-1:0] wr_word, rd_src;

  sbr_sync #(.N(3)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .d_i({cs_ni, rd_ni, wr_ni}), .q_o(strb_s)
  );

  sbr_decode #(.AW(AW), .TAG_W(TAG_W)) u_dec (
    .fifo_sel_i(fifo_sel_i), .addr_i(addr_i),
    .region_o(region), .word_idx_o(csr_addr_o), .hi_half_o(hi_half)
  );

  assign s_rd     = ~strb_s[2] & ~strb_s[1];
  assign s_wr     = ~strb_s[2] & ~strb_s[0];
  assign rd_start = s_rd & ~rd_q;
  assign rd_end   = ~s_rd & rd_q;
  assign wr_end   = ~s_wr & wr_q;
  assign is_fifo  = (region == REG_FIFO);
  assign swap_eff = fifo_swap_i & is_fifo;
  assign rd_src   = is_fifo ? rxf_data_i : csr_rdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q      <= 1'b0;
      wr_q      <= 1'b0;
      rxf_pop_o <= 1'b0;
      wake_o    <= 1'b0;
    end else begin
      rd_q      <= s_rd;
      wr_q      <= s_wr;
      rxf_pop_o <= rd_end & hi_half & is_fifo;
      wake_o    <= s_wr & low_power_i;
    end
  end

  sbr_wr_pack #(.HW(HW)) u_wr (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .lo_end_i(wr_end & ~hi_half), .hi_end_i(wr_end & hi_half),
    .swap_i(swap_eff), .to_fifo_i(is_fifo), .data_i(data_i),
    .word_o(wr_word), .push_fifo_o(txf_push_o), .push_csr_o(csr_wr_o)
  );

  sbr_rd_path #(.HW(HW)) u_rd (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .lo_start_i(rd_start & ~hi_half), .hi_start_i(rd_start & hi_half),
    .swap_i(swap_eff), .src_i(rd_src), .dout_o(data_o)
  );

  assign csr_wdata_o = wr_word;
  assign txf_data_o  = wr_word;
  assign data_oe_o   = rd_q;

  a_r1_idle_after_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !(csr_wr_o || txf_push_o || rxf_pop_o));
  a_r5_sel_blocks_csr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_wr_o |-> !$past(fifo_sel_i));
  a_r4_pop_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rxf_pop_o |=> !rxf_pop_o);
  a_r8_wake_needs_lp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> $past(low_power_i));
  a_r10_oe_needs_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> $past(!cs_ni && !rd_ni, 3));
  a_r4_push_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({csr_wr_o, txf_push_o, rxf_pop_o}));
endmodule

// File: tb/tb_sram_host_bridge.sv
module tb_sram_host_bridge;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [6:0] addr = '0;
  logic sel = 1'b0, swap = 1'b0, lp = 1'b0;
  logic [15:0] din = '0, dout;
  logic oe, wake, csr_wr, push, pop;
  logic [5:0] csr_addr;
  logic [31:0] csr_wdata, csr_rdata = '0, txf_data, rxf_data;

  int checks = 0, errors = 0;
  int n_csr = 0, n_push = 0, n_pop = 0;
  logic [31:0] last_csr, last_tx;
  logic [5:0]  last_csr_addr;
  logic [31:0] rx_mem [4];
  int rx_idx = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_host_bridge dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .rd_ni(rd_n), .wr_ni(wr_n),
    .addr_i(addr), .fifo_sel_i(sel), .fifo_swap_i(swap), .low_power_i(lp),
    .data_i(din), .data_o(dout), .data_oe_o(oe), .wake_o(wake),
    .csr_addr_o(csr_addr), .csr_wdata_o(csr_wdata), .csr_wr_o(csr_wr),
    .csr_rdata_i(csr_rdata), .txf_data_o(txf_data), .txf_push_o(push),
    .rxf_data_i(rxf_data), .rxf_pop_o(pop)
  );

  assign rxf_data = rx_mem[rx_idx % 4];

  always @(posedge clk) begin
    if (csr_wr) begin n_csr++; last_csr = csr_wdata; last_csr_addr = csr_addr; end
    if (push)   begin n_push++; last_tx = txf_data; end
    if (pop)    begin n_pop++; rx_idx++; end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [6:0] a, input logic [15:0] d, input bit use_cs = 1);
    @(negedge clk);
    addr = a; din = d; cs_n = !use_cs; wr_n = 1'b0;
    repeat (4) @(negedge clk);
    wr_n = 1'b1; cs_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic bus_rd(input logic [6:0] a, output logic [15:0] d, output logic oe_seen);
    @(negedge clk);
    addr = a; cs_n = 1'b0; rd_n = 1'b0;
    repeat (4) @(negedge clk);
    d = dout; oe_seen = oe;
    rd_n = 1'b1; cs_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset();
    check(oe == 0 && wake == 0, "R1 oe/wake", {30'b0, oe, wake}, 0);
    check(n_csr == 0 && n_push == 0 && n_pop == 0, "R1 pulses", n_csr + n_push + n_pop, 0);
  endtask

  task automatic t_csr_write();
    swap = 1'b1; // R6: ignored for registers
    bus_wr({6'h09, 1'b0}, 16'h5678);
    check(n_csr == 0, "R2 lower half alone", n_csr, 0);
    bus_wr({6'h09, 1'b1}, 16'h1234);
    check(n_csr == 1, "R2 write count", n_csr, 1);
    check(last_csr == 32'h12345678, "R6 csr word unswapped", last_csr, 32'h12345678);
    check(last_csr_addr == 6'h09, "R2 csr address", last_csr_addr, 6'h09);
    check(n_push == 0, "R2 no fifo push", n_push, 0);
    swap = 1'b0;
  endtask

  task automatic t_csr_read();
    logic [15:0] d; logic o;
    csr_rdata = 32'hAAAA5555;
    bus_rd({6'h0C, 1'b0}, d, o);
    check(d == 16'h5555, "R3 lower half", d, 16'h5555);
    check(o == 1'b1, "R10 oe during read", o, 1);
    csr_rdata = 32'h12341234;
    bus_rd({6'h0C, 1'b1}, d, o);
    check(d == 16'hAAAA, "R3 coherent upper", d, 16'hAAAA);
    check(oe == 1'b0, "R10 oe after release", oe, 0);
  endtask

  task automatic t_fifo_region();
    bus_wr(7'h00, 16'hBEEF);
    bus_wr(7'h01, 16'hDEAD);
    check(n_push == 1 && last_tx == 32'hDEADBEEF, "R4 region push", last_tx, 32'hDEADBEEF);
    check(n_csr == 1, "R4 no csr write", n_csr, 1);
  endtask

  task automatic t_fifo_sel();
    sel = 1'b1;
    bus_wr(7'h7E, 16'h0001);
    bus_wr(7'h7F, 16'hCAFE);
    check(n_push == 2 && last_tx == 32'hCAFE0001, "R5 override push", last_tx, 32'hCAFE0001);
    check(n_csr == 1, "R5 csr untouched", n_csr, 1);
    sel = 1'b0;
  endtask

  task automatic t_swap_write();
    swap = 1'b1;
    bus_wr(7'h00, 16'h1111);
    bus_wr(7'h01, 16'h2222);
    check(last_tx == 32'h11112222, "R6 swapped push", last_tx, 32'h11112222);
    swap = 1'b0;
  endtask

  task automatic t_burst_read();
    logic [15:0] d; logic o;
    bus_rd(7'h00, d, o); check(d == 16'h0C0D, "R7 w0 lo", d, 16'h0C0D);
    check(n_pop == 0, "R4 no pop on lower", n_pop, 0);
    bus_rd(7'h01, d, o); check(d == 16'h0A0B, "R7 w0 hi", d, 16'h0A0B);
    check(n_pop == 1, "R4 one pop", n_pop, 1);
    bus_rd(7'h00, d, o); check(d == 16'h3344, "R7 w1 lo", d, 16'h3344);
    bus_rd(7'h01, d, o); check(d == 16'h1122, "R7 w1 hi", d, 16'h1122);
    check(n_pop == 2, "R7 two pops", n_pop, 2);
    swap = 1'b1;
    bus_rd(7'h00, d, o); check(d == 16'h5566, "R6 swapped first", d, 16'h5566);
    bus_rd(7'h01, d, o); check(d == 16'h7788, "R6 swapped second", d, 16'h7788);
    swap = 1'b0;
  endtask

  task automatic t_wake();
    logic [15:0] d; logic o;
    lp = 1'b1;
    @(negedge clk);
    addr = {6'h10, 1'b0}; cs_n = 1'b0; wr_n = 1'b0;
    repeat (4) @(negedge clk);
    check(wake == 1'b1, "R8 wake on write", wake, 1);
    wr_n = 1'b1; cs_n = 1'b1;
    repeat (5) @(negedge clk);
    check(wake == 1'b0, "R8 wake released", wake, 0);
    bus_rd({6'h10, 1'b0}, d, o);
    check(wake == 1'b0, "R8 read no wake", wake, 0);
    lp = 1'b0;
    @(negedge clk);
    cs_n = 1'b0; wr_n = 1'b0;
    repeat (4) @(negedge clk);
    check(wake == 1'b0, "R8 no wake when awake", wake, 0);
    wr_n = 1'b1; cs_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic t_no_cs();
    int p0;
    p0 = n_push;
    bus_wr(7'h00, 16'h9999, 0);
    bus_wr(7'h01, 16'h8888, 0);
    check(n_push == p0, "R9 no push without cs", n_push, p0);
    @(negedge clk);
    addr = 7'h01; rd_n = 1'b0;
    repeat (4) @(negedge clk);
    check(oe == 1'b0, "R9 no oe without cs", oe, 0);
    rd_n = 1'b1;
    repeat (5) @(negedge clk);
    check(n_pop == 3, "R9 no pop without cs", n_pop, 3);
  endtask

  initial begin
    rx_mem[0] = 32'h0A0B0C0D; rx_mem[1] = 32'h11223344;
    rx_mem[2] = 32'h55667788; rx_mem[3] = 32'h99AABBCC;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_csr_write();
    t_csr_read();
    t_fifo_region();
    t_fifo_sel();
    t_swap_write();
    t_burst_read();
    t_wake();
    t_no_cs();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule